// File: doc/BRIEF.md
# Rate-1/2 Constraint-Length-7 Convolutional Encoder

This block turns a serial stream of data bits into a rate-1/2 convolutionally coded stream, the forward error correction code found in wireless LAN physical layers. A six-bit memory holds the previous input bits. Each input bit, together with that memory, yields two coded bits, A and B. A comes from generator 171 octal and B from generator 133 octal.

Input bits arrive through a valid/ready handshake. Coded bits leave through a registered valid/ready output that holds its value under backpressure. A run-time mode input selects one of two throughputs. In single mode the block takes one bit per clock. In pair mode it takes two bits per clock and computes two consecutive trellis steps in one cycle, which gives four coded bits. A flush request closes a frame: the block feeds six zero tail bits through the encoder, so the memory returns to the all-zero state.

Top module: `conv_enc`

## Requirements
- R1: After the active-low synchronous reset, `out_valid_o` is 0, `in_ready_o` is 1 when neither flush nor backpressure applies, and the memory is all zero. A first accepted bit of 1 in single mode therefore produces the code 4'b1100.
- R2: Let d_k be the input bit from k accepted steps earlier and u the current bit. Coded bit A is u ^ d1 ^ d2 ^ d3 ^ d6 (generator 171 octal).
- R3: Coded bit B is u ^ d2 ^ d3 ^ d5 ^ d6 (generator 133 octal).
- R4: In single mode (`pair_mode_i`=0), an accepted bit `in_bits_i[0]` appears in the next cycle with `out_valid_o`=1, `out_code_o[3:2]`={A,B}, `out_code_o[1:0]`=0 and `out_pair_o`=0. A is the first bit on the serial line.
- R5: In pair mode, `in_bits_i[0]` is the earlier bit and `in_bits_i[1]` the later one. The next cycle shows `out_code_o`={A0,B0,A1,B1} with `out_pair_o`=1, which is the same sequence as two single-mode steps.
- R6: A flush request while not flushing inserts six zero tail bits, one per output beat in single mode or two per beat in pair mode. The tail beats are coded like data. `in_ready_o` stays 0 during the request cycle and throughout the flush, and the memory is all zero when the flush ends.
- R7: While `out_valid_o`=1 and `out_ready_i`=0, the output code, pair flag and valid hold their values, and `in_ready_o` is 0.
- R8: The mode may change on any beat. The memory is shared, so the code stream continues the same trellis across a switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pair_mode_i | input | 1 | 1: two bits per beat, 0: one bit per beat |
| in_valid_i | input | 1 | Input bits are valid |
| in_ready_o | output | 1 | Block takes the input bits this cycle |
| in_bits_i | input | 2 | Data bits; bit 0 is earlier, bit 1 is used only in pair mode |
| flush_i | input | 1 | Request six zero tail bits |
| out_valid_o | output | 1 | Coded beat is valid |
| out_ready_i | input | 1 | Downstream takes the coded beat |
| out_code_o | output | 4 | Coded bits {A0,B0,A1,B1}; low pair is zero in single mode |
| out_pair_o | output | 1 | Beat carries four coded bits |

## Verification
The checker assumes that the downstream side only drops `out_ready_i` as ordinary backpressure. It also assumes that a flush request arriving during a flush has no effect, so a flush in progress always runs to the zero state. Both assumptions are only ever exercised inside these rules.

The stimulus draws valid, data, mode, flush and downstream ready at random from a fixed seed. Mode changes freely on any beat, including in the middle of a tail, and a flush request is allowed to collide with data. A bench model built from the two polynomials predicts every beat and every ready value.

// File: rtl/conv_enc_pkg.sv
// Package: shared constants and step functions for the K=7 rate-1/2 encoder.
// Assumes memory bit k-1 holds the input bit from k steps earlier.
package conv_enc_pkg;
    localparam int MEM_LEN   = 6;
    localparam int CNT_W     = $clog2(MEM_LEN + 1);
    localparam int MAX_STEPS = 2;
    // Tap masks over delays 1..6 (bit k-1 = delay k); delay 0 is always tapped.
    localparam logic [MEM_LEN-1:0] TAPS_A = 6'b100111;
    localparam logic [MEM_LEN-1:0] TAPS_B = 6'b110110;

    typedef logic [MEM_LEN-1:0] mem_t;

    // Two coded bits {A,B} for memory m and current bit u.
    function automatic logic [1:0] code_pair(mem_t m, logic u);
        return {u ^ (^(m & TAPS_A)), u ^ (^(m & TAPS_B))};
    endfunction

    // Memory after shifting in bit u.
    function automatic mem_t shift_in(mem_t m, logic u);
        return {m[MEM_LEN-2:0], u};
    endfunction
endpackage

// File: rtl/conv_trellis.sv
// Module: combinational unrolled trellis of MAX_STEPS consecutive steps.
// Assumes bits[0] is the earliest bit. It gives the codes of every step
// and the memory after one step and after all steps.
module conv_trellis
    import conv_enc_pkg::*;
(
    input  mem_t                     mem_i,
    input  logic [MAX_STEPS-1:0]     bits_i,
    output logic [2*MAX_STEPS-1:0]   code_o,
    output mem_t                     next1_o,
    output mem_t                     next_all_o
);
    mem_t chain [MAX_STEPS+1];

    assign chain[0] = mem_i;

    for (genvar s = 0; s < MAX_STEPS; s++) begin : g_step
        // One trellis step: emit {A,B}, then advance the memory.
        assign code_o[2*MAX_STEPS-1-2*s -: 2] = code_pair(chain[s], bits_i[s]);
        assign chain[s+1] = shift_in(chain[s], bits_i[s]);
    end

    assign next1_o    = chain[1];
    assign next_all_o = chain[MAX_STEPS];
endmodule

// File: rtl/conv_tail_ctrl.sv
// Module: counts the zero tail bits still owed after a flush request.
// Assumes a request made during a flush is ignored, and that a step
// consumes two tail bits only when pair mode is set and two remain.
module conv_tail_ctrl
    import conv_enc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic step_i,
    input  logic pair_mode_i,
    output logic flushing_o,
    output logic tail_two_o
);
    logic [CNT_W-1:0] remain_q;

    assign flushing_o = (remain_q != '0);
    assign tail_two_o = pair_mode_i && (remain_q >= CNT_W'(2));

    // Load the tail length on a request, count down as tail steps leave.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (start_i && !flushing_o) begin
            remain_q <= CNT_W'(MEM_LEN);
        end else if (step_i) begin
            remain_q <= remain_q - (tail_two_o ? CNT_W'(2) : CNT_W'(1));
        end
    end
endmodule

// File: rtl/conv_out_stage.sv
// Module: encoder memory plus the registered output beat.
// Assumes load_i is asserted only when the beat may advance (adv_i).
module conv_out_stage
    import conv_enc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   adv_i,
    input  logic                   load_i,
    input  logic                   two_i,
    input  logic [2*MAX_STEPS-1:0] code_i,
    input  mem_t                   next1_i,
    input  mem_t                   next_all_i,
    output mem_t                   mem_o,
    output logic                   valid_o,
    output logic [2*MAX_STEPS-1:0] code_o,
    output logic                   pair_o
);
    // Advance the memory by one or two steps when a beat is produced.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_o <= '0;
        end else if (load_i) begin
            mem_o <= two_i ? next_all_i : next1_i;
        end
    end

    // Register the coded beat; hold it while downstream stalls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            code_o  <= '0;
            pair_o  <= 1'b0;
        end else if (adv_i) begin
            valid_o <= load_i;
            if (load_i) begin
                code_o <= two_i ? code_i : {code_i[2*MAX_STEPS-1 -: 2], {(2*MAX_STEPS-2){1'b0}}};
                pair_o <= two_i;
            end
        end
    end
endmodule

// File: rtl/conv_enc.sv
// Module: top of the rate-1/2, K=7 convolutional encoder (171/133 octal).
// Assumes in_bits_i[0] is the earlier bit in pair mode. Flush inserts six
// zero tail bits and blocks input until the memory is back at zero.
module conv_enc
    import conv_enc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pair_mode_i,
    input  logic       in_valid_i,
    output logic       in_ready_o,
    input  logic [1:0] in_bits_i,
    input  logic       flush_i,
    output logic       out_valid_o,
    input  logic       out_ready_i,
    output logic [3:0] out_code_o,
    output logic       out_pair_o
);
    logic                   adv;
    logic                   flushing;
    logic                   tail_two;
    logic                   take_data;
    logic                   take_tail;
    logic                   use_two;
    logic [MAX_STEPS-1:0]   step_bits;
    logic [2*MAX_STEPS-1:0] step_code;
    mem_t                   state_q;
    mem_t                   next1;
    mem_t                   next_all;

    // Handshake and step selection.
    assign adv        = !out_valid_o || out_ready_i;
    assign in_ready_o = !flushing && !flush_i && adv;
    assign take_data  = in_valid_i && in_ready_o;
    assign take_tail  = flushing && adv;
    assign step_bits  = take_tail ? '0 : in_bits_i;
    assign use_two    = take_tail ? tail_two : pair_mode_i;

    conv_trellis trellis_i (
        .mem_i      (state_q),
        .bits_i     (step_bits),
        .code_o     (step_code),
        .next1_o    (next1),
        .next_all_o (next_all)
    );

    conv_tail_ctrl tail_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (flush_i),
        .step_i      (take_tail),
        .pair_mode_i (pair_mode_i),
        .flushing_o  (flushing),
        .tail_two_o  (tail_two)
    );

    conv_out_stage stage_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_i      (adv),
        .load_i     (take_data || take_tail),
        .two_i      (use_two),
        .code_i     (step_code),
        .next1_i    (next1),
        .next_all_i (next_all),
        .mem_o      (state_q),
        .valid_o    (out_valid_o),
        .code_o     (out_code_o),
        .pair_o     (out_pair_o)
    );
endmodule

// File: rtl/conv_enc_chk.sv
// Module: assertion checker attached to conv_enc by bind.
// Assumes it sees the top's ports plus its flush state and memory.
module conv_enc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pair_mode_i,
    input logic       in_valid_i,
    input logic       in_ready_o,
    input logic       out_valid_o,
    input logic       out_ready_i,
    input logic [3:0] out_code_o,
    input logic       out_pair_o,
    input logic       flushing,
    input logic [5:0] state_q
);
    AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_code_o) && $stable(out_pair_o)); // R7
    AST_STALL_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !out_ready_i |-> !in_ready_o); // R7
    AST_FLUSH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        flushing |-> !in_ready_o); // R6
    AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flushing) |-> state_q == 6'd0); // R6
    AST_TAKE_GIVES_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i && in_ready_o |=> out_valid_o); // R4
    AST_PAIR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i && in_ready_o && pair_mode_i |=> out_pair_o); // R5
    AST_SINGLE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !out_pair_o |-> out_code_o[1:0] == 2'b00); // R4
endmodule

bind conv_enc conv_enc_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pair_mode_i (pair_mode_i),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_code_o  (out_code_o),
    .out_pair_o  (out_pair_o),
    .flushing    (flushing),
    .state_q     (state_q)
);

// File: tb/conv_enc_tb_top.sv
// Bench: random plus directed stimulus against a polynomial reference model.
module conv_enc_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pair_mode_i = 1'b0;
    logic       in_valid_i = 1'b0;
    logic [1:0] in_bits_i = 2'b00;
    logic       flush_i = 1'b0;
    logic       out_ready_i = 1'b1;
    logic       in_ready_o;
    logic       out_valid_o;
    logic [3:0] out_code_o;
    logic       out_pair_o;

    int checks = 0;
    int fails  = 0;

    logic [5:0] m_mem = '0;
    int         m_tail = 0;
    logic       e_valid = 1'b0;
    logic [3:0] e_code = '0;
    logic       e_pair = 1'b0;

    always #4 clk = ~clk;

    conv_enc dut_i (
        .clk(clk), .rst_n(rst_n), .pair_mode_i(pair_mode_i),
        .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_bits_i(in_bits_i),
        .flush_i(flush_i), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
        .out_code_o(out_code_o), .out_pair_o(out_pair_o)
    );

    // Reference: R2 generator 171, R3 generator 133; m[k-1] is delay k.
    function automatic logic [1:0] ref_ab(logic [5:0] m, logic u);
        logic a, b;
        a = u ^ m[0] ^ m[1] ^ m[2] ^ m[5];
        b = u ^ m[1] ^ m[2] ^ m[4] ^ m[5];
        return {a, b};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Predict one beat from the reference memory.
    task automatic ref_step(input logic [1:0] b, input logic two);
        logic [1:0] p0, p1;
        p0 = ref_ab(m_mem, b[0]);
        m_mem = {m_mem[4:0], b[0]};
        if (two) begin
            p1 = ref_ab(m_mem, b[1]);
            m_mem = {m_mem[4:0], b[1]};
            e_code = {p0, p1};
        end else begin
            e_code = {p0, 2'b00};
        end
        e_pair = two;
        e_valid = 1'b1;
    endtask

    // One clock: drive at negedge, check ready, predict, check the beat.
    task automatic cycle(input logic v, input logic [1:0] b, input logic pm,
                         input logic fl, input logic ordy);
        logic exp_rdy, adv, two;
        int   tail0;
        in_valid_i = v; in_bits_i = b; pair_mode_i = pm; flush_i = fl; out_ready_i = ordy;
        #1;
        exp_rdy = (m_tail == 0) && !fl && (!e_valid || ordy);
        check(in_ready_o == exp_rdy, (m_tail != 0 || fl) ? "R6 ready" : "R7 ready",
              int'(in_ready_o), int'(exp_rdy));
        adv = !e_valid || ordy;
        tail0 = m_tail;
        if (adv) begin
            if (m_tail > 0) begin
                two = pm && (m_tail >= 2);
                ref_step(2'b00, two);
                m_tail -= two ? 2 : 1;
            end else if (v && exp_rdy) begin
                ref_step(b, pm);
            end else begin
                e_valid = 1'b0;
            end
        end
        if (fl && tail0 == 0) m_tail = 6;
        @(posedge clk);
        @(negedge clk);
        check(out_valid_o == e_valid, "R4/R7 valid", int'(out_valid_o), int'(e_valid));
        if (e_valid) begin
            check(out_code_o == e_code, e_pair ? "R5 R2/R3 code" : "R4 R2/R3 code",
                  int'(out_code_o), int'(e_code));
            check(out_pair_o == e_pair, "R5 pair flag", int'(out_pair_o), int'(e_pair));
        end
    endtask

    initial begin
        #1_600_000;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check(out_valid_o == 1'b0, "R1 valid", int'(out_valid_o), 0);
        check(in_ready_o == 1'b1, "R1 ready", int'(in_ready_o), 1);
        @(negedge clk);
        // R1: first bit 1 from the zero state gives 4'b1100
        cycle(1'b1, 2'b01, 1'b0, 1'b0, 1'b1);
        check(out_code_o == 4'b1100, "R1 first code", int'(out_code_o), 12);
        // R2/R3: walk the impulse through the memory in single mode
        for (int i = 0; i < 6; i++) cycle(1'b1, 2'b00, 1'b0, 1'b0, 1'b1);
        // R5: pair mode beats
        cycle(1'b1, 2'b10, 1'b1, 1'b0, 1'b1);
        cycle(1'b1, 2'b11, 1'b1, 1'b0, 1'b1);
        // R7: stall with input offered, then release
        cycle(1'b1, 2'b01, 1'b0, 1'b0, 1'b0);
        cycle(1'b1, 2'b01, 1'b0, 1'b0, 1'b0);
        cycle(1'b1, 2'b01, 1'b0, 1'b0, 1'b1);
        // R6: flush in single mode, data offered throughout
        cycle(1'b1, 2'b11, 1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 7; i++) cycle(1'b1, 2'b11, 1'b0, 1'b0, 1'b1);
        // R6/R8: flush in pair mode, switching mode mid-tail
        cycle(1'b0, 2'b00, 1'b1, 1'b1, 1'b1);
        cycle(1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 6; i++) cycle(1'b1, 2'b01, 1'b1, 1'b0, 1'b1);
        // Random mix: R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < 4000; i++) begin
            cycle(1'(($urandom % 4) != 0), 2'($urandom), 1'($urandom),
                  1'(($urandom % 40) == 0), 1'(($urandom % 4) != 0));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule